// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block works out the output frequency of a phase-locked loop from its reference frequency and its divider settings. A caller presents a 32-bit reference rate, a 6-bit input divider, a 12-bit loop multiplier, a 24-bit fractional word, two 3-bit output dividers and a mode select, then pulses `start_i`. Some cycles later the block returns a 32-bit rate together with a one-cycle `done_o`.

The computation runs in a fixed sequence. First the reference is divided by the input divider, with truncation. That quotient is multiplied by the loop multiplier. In fractional mode the term `(fref * frac) >> 24` is added, with the product formed at 56 bits. The oscillator rate is then divided by the first output divider and that quotient by the second, truncating each time. Every division uses a shared restoring shift-subtract divider that produces one quotient bit per cycle. No divide operator is used.

A zero reference rate short-cuts to a zero result. A zero in any divider field is reported as an error with a zero result and no division is attempted.

Top module: `pll_rate_calc`

## Requirements
- R1: With `int_mode_i` = 1 the result is `(fref / refdiv) * fbdiv`, with truncating division, and `frac_i` has no effect.
- R2: With `int_mode_i` = 0 the result is `(fref / refdiv) * fbdiv + ((fref * frac) >> 24)`, with the product taken at full 56-bit width.
- R3: The oscillator rate, kept at 45 bits, is divided by `postdiv1_i` and then by `postdiv2_i`, truncating after each step. `rate_o` carries the low 32 bits of that final quotient.
- R4: A zero `fref_i` with all divider fields nonzero gives `rate_o` = 0 and `err_o` = 0, with `done_o` high in the cycle after the accepting edge.
- R5: If any of `refdiv_i`, `fbdiv_i`, `postdiv1_i` or `postdiv2_i` is zero, the block gives `rate_o` = 0 and `err_o` = 1, with `done_o` high in the cycle after the accepting edge. This takes priority over R4.
- R6: `done_o` is high for exactly one cycle for each accepted request. `rate_o` and `err_o` are valid while `done_o` is high.
- R7: A `start_i` pulse while `busy_o` is high is ignored: it produces no result and does not change the result in flight.
- R8: Operands are captured at the accepting edge. Changing the inputs afterwards does not alter the result.
- R9: `busy_o` is high from the cycle after a request that needs division is accepted until its `done_o` cycle. After reset `busy_o`, `done_o`, `err_o` and `rate_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted when not busy |
| fref_i | input | 32 | Reference frequency |
| refdiv_i | input | 6 | Input (reference) divider |
| fbdiv_i | input | 12 | Loop feedback multiplier |
| frac_i | input | 24 | Fractional word, weight 2^-24 |
| postdiv1_i | input | 3 | First output divider |
| postdiv2_i | input | 3 | Second output divider |
| int_mode_i | input | 1 | 1 = integer mode, 0 = fractional mode |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Zero divider field seen (valid with done_o) |
| rate_o | output | 32 | Computed output frequency (valid with done_o) |

## Verification
Some properties are checked by assertions on every cycle:
- the single-cycle `done_o`;
- the zero-rate and error short-cuts after an accepting edge;
- that captured operands hold still while busy;
- that the divider's remainder is below its divisor when it finishes.

The arithmetic itself can only be shown by the scenarios:
- integer against fractional formulas;
- the truncating reference division;
- the 45-bit oscillator value with its low-32-bit result;
- starts ignored while busy;
- inputs changed after acceptance.

In these scenarios a scoreboard compares each result with an independently computed value.

// File: rtl/pllrc_pkg.sv
package pllrc_pkg;
  localparam int FREF_W    = 32;
  localparam int REFDIV_W  = 6;
  localparam int FBDIV_W   = 12;
  localparam int FRAC_W    = 24;
  localparam int POSTDIV_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_VCO,
    ST_POST1,
    ST_POST2
  } calc_state_t;
endpackage

// File: rtl/pllrc_divider.sv
module pllrc_divider #(
  parameter int NW = 45,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quotient
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q_r;
  logic [DW-1:0] rem_r;
  logic [DW-1:0] dvs_r;
  logic [CW-1:0] cnt_r;
  logic          run_r;
  logic          done_r;

  logic [DW:0]   trial;
  logic          ge;
  logic [DW-1:0] nrem;

  always_comb begin
    trial = {rem_r, q_r[NW-1]};
    ge    = trial >= {1'b0, dvs_r};
    nrem  = ge ? DW'(trial - {1'b0, dvs_r}) : DW'(trial);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r    <= '0;
      rem_r  <= '0;
      dvs_r  <= '0;
      cnt_r  <= '0;
      run_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start && !run_r) begin
        q_r   <= dividend;
        rem_r <= '0;
        dvs_r <= divisor;
        cnt_r <= CW'(NW);
        run_r <= 1'b1;
      end else if (run_r) begin
        rem_r <= nrem;
        q_r   <= {q_r[NW-2:0], ge};
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CW'(1)) begin
          run_r  <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign done     = done_r;
  assign quotient = q_r;

  // R3
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (rst)
    done_r |-> (rem_r < dvs_r));
endmodule

// File: rtl/pllrc_vco.sv
module pllrc_vco #(
  parameter int FW = 32,
  parameter int BW = 12,
  parameter int RW = 24,
  parameter int VW = 45
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] base,
  input  logic [BW-1:0] fbdiv,
  input  logic [FW-1:0] fref,
  input  logic [RW-1:0] frac,
  input  logic          int_mode,
  output logic [VW-1:0] vco
);
  localparam int PW = FW + RW;

  logic [PW-1:0] prod;
  logic [FW-1:0] frac_term;
  logic [VW-1:0] int_part;
  logic [VW-1:0] vco_r;

  always_comb begin
    prod      = PW'(fref) * PW'(frac);
    frac_term = FW'(prod >> RW);
    int_part  = VW'(base) * VW'(fbdiv);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vco_r <= '0;
    end else if (load) begin
      vco_r <= int_mode ? int_part : int_part + VW'(frac_term);
    end
  end

  assign vco = vco_r;
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pllrc_pkg::*;
#(
  parameter int FW = FREF_W,
  parameter int RDW = REFDIV_W,
  parameter int BW = FBDIV_W,
  parameter int RW = FRAC_W,
  parameter int PDW = POSTDIV_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [FW-1:0]  fref_i,
  input  logic [RDW-1:0] refdiv_i,
  input  logic [BW-1:0]  fbdiv_i,
  input  logic [RW-1:0]  frac_i,
  input  logic [PDW-1:0] postdiv1_i,
  input  logic [PDW-1:0] postdiv2_i,
  input  logic           int_mode_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic [FW-1:0]  rate_o
);
  localparam int VW   = FW + BW + 1;
  localparam int DIVW = (RDW > PDW) ? RDW : PDW;

  calc_state_t state_r;

  logic [FW-1:0]  fref_q;
  logic [RDW-1:0] refdiv_q;
  logic [BW-1:0]  fbdiv_q;
  logic [RW-1:0]  frac_q;
  logic [PDW-1:0] pd1_q;
  logic [PDW-1:0] pd2_q;
  logic           int_q;

  logic [FW-1:0]  base_r;
  logic [VW-1:0]  stage_r;
  logic [FW-1:0]  rate_r;
  logic           done_r;
  logic           err_r;
  logic           kick_r;

  logic [VW-1:0]   div_num;
  logic [DIVW-1:0] div_den;
  logic            div_done;
  logic [VW-1:0]   div_quot;
  logic [VW-1:0]   vco;
  logic            any_zero_div;

  assign any_zero_div = (refdiv_i == '0) || (fbdiv_i == '0) ||
                        (postdiv1_i == '0) || (postdiv2_i == '0);

  always_comb begin
    div_num = VW'(fref_q);
    div_den = DIVW'(refdiv_q);
    case (state_r)
      ST_POST1: begin
        div_num = vco;
        div_den = DIVW'(pd1_q);
      end
      ST_POST2: begin
        div_num = stage_r;
        div_den = DIVW'(pd2_q);
      end
      default: ;
    endcase
  end

  pllrc_divider #(.NW(VW), .DW(DIVW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (kick_r),
    .dividend (div_num),
    .divisor  (div_den),
    .done     (div_done),
    .quotient (div_quot)
  );

  pllrc_vco #(.FW(FW), .BW(BW), .RW(RW), .VW(VW)) u_vco (
    .clk      (clk),
    .rst      (rst),
    .load     (state_r == ST_VCO),
    .base     (base_r),
    .fbdiv    (fbdiv_q),
    .fref     (fref_q),
    .frac     (frac_q),
    .int_mode (int_q),
    .vco      (vco)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_r  <= ST_IDLE;
      fref_q   <= '0;
      refdiv_q <= '0;
      fbdiv_q  <= '0;
      frac_q   <= '0;
      pd1_q    <= '0;
      pd2_q    <= '0;
      int_q    <= 1'b0;
      base_r   <= '0;
      stage_r  <= '0;
      rate_r   <= '0;
      done_r   <= 1'b0;
      err_r    <= 1'b0;
      kick_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      kick_r <= 1'b0;
      case (state_r)
        ST_IDLE: begin
          if (start_i) begin
            fref_q   <= fref_i;
            refdiv_q <= refdiv_i;
            fbdiv_q  <= fbdiv_i;
            frac_q   <= frac_i;
            pd1_q    <= postdiv1_i;
            pd2_q    <= postdiv2_i;
            int_q    <= int_mode_i;
            if (any_zero_div) begin
              rate_r <= '0;
              err_r  <= 1'b1;
              done_r <= 1'b1;
            end else if (fref_i == '0) begin
              rate_r <= '0;
              err_r  <= 1'b0;
              done_r <= 1'b1;
            end else begin
              state_r <= ST_REF;
              kick_r  <= 1'b1;
            end
          end
        end
        ST_REF: begin
          if (div_done) begin
            base_r  <= div_quot[FW-1:0];
            state_r <= ST_VCO;
          end
        end
        ST_VCO: begin
          state_r <= ST_POST1;
          kick_r  <= 1'b1;
        end
        ST_POST1: begin
          if (div_done) begin
            stage_r <= div_quot;
            state_r <= ST_POST2;
            kick_r  <= 1'b1;
          end
        end
        ST_POST2: begin
          if (div_done) begin
            rate_r  <= div_quot[FW-1:0];
            err_r   <= 1'b0;
            done_r  <= 1'b1;
            state_r <= ST_IDLE;
          end
        end
        default: state_r <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_r != ST_IDLE);
  assign done_o = done_r;
  assign err_o  = err_r;
  assign rate_o = rate_r;

  // R6
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5
  zero_divider_err_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && any_zero_div) |=> (done_o && err_o && rate_o == '0));

  // R4
  zero_ref_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !any_zero_div && fref_i == '0)
      |=> (done_o && !err_o && rate_o == '0));

  // R7
  operands_held_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy_o) |-> ($stable(fref_q) && $stable(refdiv_q) && $stable(fbdiv_q) &&
                       $stable(frac_q) && $stable(pd1_q) && $stable(pd2_q) &&
                       $stable(int_q)));
endmodule

// File: tb/pll_rate_calc_bench.sv
module pll_rate_calc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] fref_i = '0;
  logic [5:0]  refdiv_i = '0;
  logic [11:0] fbdiv_i = '0;
  logic [23:0] frac_i = '0;
  logic [2:0]  postdiv1_i = '0;
  logic [2:0]  postdiv2_i = '0;
  logic        int_mode_i = 1'b0;
  logic        busy_o, done_o, err_o;
  logic [31:0] rate_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] rate;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  pll_rate_calc u_pll_rate_calc (
    .clk(clk), .rst(rst), .start_i(start_i), .fref_i(fref_i),
    .refdiv_i(refdiv_i), .fbdiv_i(fbdiv_i), .frac_i(frac_i),
    .postdiv1_i(postdiv1_i), .postdiv2_i(postdiv2_i), .int_mode_i(int_mode_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rate_o(rate_o)
  );

  function automatic exp_t model(input logic [31:0] f, input logic [5:0] rd,
                                 input logic [11:0] fb, input logic [23:0] fr,
                                 input logic [2:0] p1, input logic [2:0] p2,
                                 input logic im, input string tag);
    exp_t e;
    longint unsigned b, v, r;
    e.tag = tag;
    if (rd == 0 || fb == 0 || p1 == 0 || p2 == 0) begin
      e.rate = 0; e.err = 1;
    end else if (f == 0) begin
      e.rate = 0; e.err = 0;
    end else begin
      b = longint'(f) / longint'(rd);
      v = b * longint'(fb);
      if (!im) v = v + ((longint'(f) * longint'(fr)) >> 24);
      r = (v / longint'(p1)) / longint'(p2);
      e.rate = r[31:0]; e.err = 0;
    end
    return e;
  endfunction

  // scoreboard monitor
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R7: unexpected result rate=%0d err=%0b expected no result", rate_o, err_o);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (rate_o !== e.rate || err_o !== e.err) begin
            fails++;
            $display("FAIL %s: rate=%0d err=%0b expected rate=%0d err=%0b",
                     e.tag, rate_o, err_o, e.rate, e.err);
          end
        end
      end
      if (done_o && prev_done) begin
        checks++; fails++;
        $display("FAIL R6: done high 2 cycles, got 1 expected 0");
      end
      prev_done = done_o;
    end
  end

  task automatic run_op(input logic [31:0] f, input logic [5:0] rd,
                        input logic [11:0] fb, input logic [23:0] fr,
                        input logic [2:0] p1, input logic [2:0] p2,
                        input logic im, input string tag, input int mode_extra);
    bit quick;
    quick = (rd == 0 || fb == 0 || p1 == 0 || p2 == 0 || f == 0);
    @(negedge clk);
    fref_i = f; refdiv_i = rd; fbdiv_i = fb; frac_i = fr;
    postdiv1_i = p1; postdiv2_i = p2; int_mode_i = im; start_i = 1'b1;
    sb.push_back(model(f, rd, fb, fr, p1, p2, im, tag));
    @(negedge clk);
    start_i = 1'b0;
    if (!quick) begin
      checks++;
      if (busy_o !== 1'b1) begin
        fails++;
        $display("FAIL R9: busy=%0b expected 1", busy_o);
      end
    end
    if (mode_extra == 1) begin
      // R8: scramble inputs after acceptance
      fref_i = 32'hDEAD_BEEF; refdiv_i = 6'd5; fbdiv_i = 12'd7;
      frac_i = 24'h123456; postdiv1_i = 3'd3; postdiv2_i = 3'd5; int_mode_i = ~im;
    end else if (mode_extra == 2) begin
      // R7: new start while busy must be ignored
      repeat (20) @(negedge clk);
      fref_i = 32'd1000; refdiv_i = 6'd1; fbdiv_i = 12'd1;
      postdiv1_i = 3'd1; postdiv2_i = 3'd1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (busy_o !== 0 || done_o !== 0 || err_o !== 0 || rate_o !== 0) begin
      fails++;
      $display("FAIL R9: reset state busy=%0b done=%0b err=%0b rate=%0d expected all 0",
               busy_o, done_o, err_o, rate_o);
    end
    // R1 integer mode
    run_op(32'd24000000, 6'd1, 12'd50, 24'd0, 3'd1, 3'd1, 1'b1, "R1", 0);
    run_op(32'd24000000, 6'd1, 12'd68, 24'd0, 3'd2, 3'd2, 1'b1, "R1", 0);
    run_op(32'd24000000, 6'd1, 12'd50, 24'hABCDEF, 3'd1, 3'd1, 1'b1, "R1", 0);
    run_op(32'd25000000, 6'd3, 12'd100, 24'd0, 3'd3, 3'd1, 1'b1, "R1", 0);
    // R2 fractional mode
    run_op(32'd24000000, 6'd1, 12'd50, 24'h800000, 3'd1, 3'd1, 1'b0, "R2", 0);
    run_op(32'd24000000, 6'd2, 12'd99, 24'h0F0F0F, 3'd4, 3'd4, 1'b0, "R2", 0);
    run_op(32'hFFFF_FFFF, 6'd1, 12'd1, 24'hFFFFFF, 3'd1, 3'd1, 1'b0, "R2", 0);
    // R3 post-divider order and 32-bit result
    run_op(32'd1000003, 6'd1, 12'd7, 24'd0, 3'd7, 3'd3, 1'b1, "R3", 0);
    run_op(32'hFFFF_FFFF, 6'd63, 12'd4095, 24'hFFFFFF, 3'd7, 3'd7, 1'b0, "R3", 0);
    run_op(32'hFFFF_FFFF, 6'd1, 12'd4095, 24'd0, 3'd1, 3'd1, 1'b1, "R3", 0);
    // R4 zero reference
    run_op(32'd0, 6'd1, 12'd50, 24'h123, 3'd1, 3'd1, 1'b0, "R4", 0);
    // R5 zero dividers
    run_op(32'd24000000, 6'd0, 12'd50, 24'd0, 3'd1, 3'd1, 1'b1, "R5", 0);
    run_op(32'd24000000, 6'd1, 12'd0, 24'd0, 3'd1, 3'd1, 1'b1, "R5", 0);
    run_op(32'd24000000, 6'd1, 12'd50, 24'd0, 3'd0, 3'd1, 1'b1, "R5", 0);
    run_op(32'd0, 6'd1, 12'd50, 24'd0, 3'd1, 3'd0, 1'b1, "R5", 0);
    // R8 inputs changed after acceptance
    run_op(32'd27000000, 6'd1, 12'd27, 24'h400000, 3'd6, 3'd4, 1'b0, "R8", 1);
    // R7 start ignored while busy
    run_op(32'd24000000, 6'd1, 12'd72, 24'd0, 3'd4, 3'd2, 1'b1, "R7", 2);
    // spread of operands
    for (int i = 0; i < 12; i++) begin
      run_op($urandom, 6'($urandom_range(1, 63)), 12'($urandom_range(1, 4095)),
             24'($urandom), 3'($urandom_range(1, 7)), 3'($urandom_range(1, 7)),
             1'($urandom), "R2", 0);
    end
    repeat (5) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R6: %0d results missing, expected 0", sb.size());
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule